// File: doc/BRIEF.md
# Bidirectional GPIO Port Bank

This block holds seven 8-bit bidirectional I/O ports, 56 lines in all. Each port has an output latch and a direction register. Both sit on a small single-cycle register bus. Writes take effect at the clock edge, and read data is combinational from the address. Each line drives a pad output value and a pad output enable, and it samples a pad input through a two-flop synchronizer. When a direction bit is 1, the line is an input. When it is 0, the line is a push-pull output that drives its latch.

A data read is built bit by bit. An input bit returns the synchronized pad level, and an output bit returns the latch. A bit-operation strobe on the same bus takes this composite value, sets, clears or toggles one bit of it (or inverts the whole byte), and writes the result into the addressed register. This gives the read-modify-write that software bit instructions need.

Port A input lines raise a one-cycle wake request whenever their synchronized level changes. An enable input turns on a buzzer mode on the two lowest port B lines. In this mode the lines carry a divide-by-two of a timer overflow pulse and its complement, gated only by the port B bit 0 latch. Pull-high presence is a per-line parameter and is only reported as a floating-status output.

Top module: `gpio_port_bank`

## Requirements
- R1: Port k (k = 0..6, port A = 0) has its latch at bus address 0x12+2k and its direction register at 0x13+2k. A write stores the data there, and a read of the direction address returns the register. Any address outside 0x12..0x1F reads as 0x00, and writes to it change nothing.
- R2: A line whose direction bit is 0 drives `pad_oe`=1 and `pad_out` equal to its latch bit. A line whose direction bit is 1 drives `pad_oe`=0. Line k*8+i belongs to port k, bit i.
- R3: A read of a data address returns, for each bit, the pad level if the direction bit is 1, or the latch bit if the direction bit is 0. A pad change becomes visible after two rising clock edges.
- R4: A latch keeps its value until its own data address is written again, including while its lines are inputs.
- R5: After reset every direction bit and every latch bit is 1, all lines are inputs, and `wake_req` is 0.
- R6: `bus_bop`=1 reads the addressed register as in R3 (or the direction register), modifies it, and writes the result back at the edge. The modification depends on `bus_bop_kind`: 00 sets bit `bus_bop_bit`, 01 clears it, 10 toggles it, and 11 inverts all eight bits.
- R7: `wake_req` is 1 for exactly one cycle, two rising edges after a pad change on a port A line that is an input. Changes on port A output lines and on other ports never assert it.
- R8: With `buzz_en`=1 and the port B bit 0 latch at 1, the output value of line 8 is a toggle state and line 9 is its complement. The toggle state flips on each cycle that has `tmr_ovf`=1, and it clears to 0 on every edge with `buzz_en`=0.
- R9: With `buzz_en`=1 and the port B bit 0 latch at 0, lines 8 and 9 both output 0. The port B bit 1 latch has no effect on them.
- R10: Enabling buzzer mode changes neither the output enables of lines 8 and 9 nor the value their input bits read.
- R11: `pad_float` is 1 for a line that is an input and has no pull-high (the `PULL_HIGH` bit is 0), and 0 otherwise.
- R12: When `bus_wr` and `bus_bop` are both 1 in one cycle, the plain write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| bus_bop | input | 1 | Bit-operation strobe |
| bus_bop_bit | input | 3 | Bit index for the bit operation |
| bus_bop_kind | input | 2 | Bit-operation kind (see R6) |
| pad_in | input | 56 | Pad input levels |
| pad_oe | output | 56 | Pad output enables |
| pad_out | output | 56 | Pad output values |
| pad_float | output | 56 | Line is an input without pull-high |
| wake_req | output | 1 | Port A change wake request |
| buzz_en | input | 1 | Buzzer mode on lines 8 and 9 |
| tmr_ovf | input | 1 | Timer overflow pulse |

## Verification
The hardest case to reach is a bit operation whose result depends on pad levels rather than on the latch. To set it up, the bench makes the upper half of a port an input, drives pad levels there that differ from the stored latch, and only then issues the set operation. It then turns every bit into an output, so that the read shows the pad levels were copied into the latch. The buzzer gate needs a similar sequence. The bench counts timer pulses while bit 0 is cleared, then re-enables the gate, which proves that the toggle kept running while the pins were held low.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int GPIO_PORT_W = 8;
  localparam int GPIO_NUM_PORTS = 7;

  typedef enum logic [1:0] {
    BOP_SET = 2'b00,
    BOP_CLR = 2'b01,
    BOP_TGL = 2'b10,
    BOP_INV = 2'b11
  } bop_kind_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int LINES = 56,
  parameter int WAKE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pad_in,
  input  logic [WAKE_W-1:0] wake_mask,
  output logic [LINES-1:0] pad_sync,
  output logic             wake_req
);
  logic [LINES-1:0]  meta_q, sync_q;
  logic [WAKE_W-1:0] prev_q;
  logic [WAKE_W-1:0] prev_d;

  always_comb begin
    prev_d = sync_q[WAKE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= prev_d;
    end
  end

  assign pad_sync = sync_q;
  assign wake_req = |((sync_q[WAKE_W-1:0] ^ prev_q) & wake_mask);

  // R7: a wake request needs a real change of the synchronized port A level
  a_r7_wake_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (pad_sync[WAKE_W-1:0] != $past(pad_sync[WAKE_W-1:0])));
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic [W-1:0] wval,
  input  logic [W-1:0] pad_sync,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] latch_d, dir_d;

  always_comb begin
    latch_d = data_we ? wval : latch_q;
    dir_d   = dir_we  ? wval : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      dir_q   <= '1;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end

  assign rd_val = (dir_q & pad_sync) | (~dir_q & latch_q);

  // R4: latch holds whenever it is not written
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(latch_q));
endmodule

// File: rtl/gpio_buzz.sv
module gpio_buzz (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ovf,
  input  logic gate,
  output logic buz_a,
  output logic buz_b
);
  logic tog_q, tog_d;

  always_comb begin
    if (!en)      tog_d = 1'b0;
    else if (ovf) tog_d = ~tog_q;
    else          tog_d = tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign buz_a = gate & tog_q;
  assign buz_b = gate & ~tog_q;

  // R8: each overflow while enabled flips the pin pair
  a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ovf && gate && $past(gate)) |=> (buz_a != $past(buz_a)) || !gate);
  // R8: complementary pins while gated on
  a_r8_complement: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (buz_a != buz_b));
  // R9: both pins low when the gate bit is 0
  a_r9_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> (!buz_a && !buz_b));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int PORT_W = GPIO_PORT_W,
  parameter int NUM_PORTS = GPIO_NUM_PORTS,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h12,
  parameter int BUZ_PORT = 1,
  parameter logic [NUM_PORTS*PORT_W-1:0] PULL_HIGH = 56'h00_0000_0000_00FF,
  localparam int LINES = NUM_PORTS * PORT_W,
  localparam int SEL_W = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic              bus_bop,
  input  logic [SEL_W-1:0]  bus_bop_bit,
  input  logic [1:0]        bus_bop_kind,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_oe,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_float,
  output logic              wake_req,
  input  logic              buzz_en,
  input  logic              tmr_ovf
);
  localparam int REG_SPAN = 2 * NUM_PORTS;
  localparam int IDX_W = $clog2(NUM_PORTS);

  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  logic [ADDR_W-1:0] offs;
  logic              hit, is_dir;
  logic [IDX_W-1:0]  port_idx;
  logic [PORT_W-1:0] cur_val, mod_val, wr_val;
  logic              write_go;
  logic [NUM_PORTS-1:0] data_we, dir_we;
  logic [PORT_W-1:0] latch_q [NUM_PORTS];
  logic [PORT_W-1:0] dir_q   [NUM_PORTS];
  logic [PORT_W-1:0] rd_val  [NUM_PORTS];
  logic [LINES-1:0]  pad_sync;
  logic              buz_a, buz_b;

  always_comb begin
    offs     = bus_addr - BASE_ADDR;
    hit      = (bus_addr >= BASE_ADDR) && (offs < ADDR_W'(REG_SPAN));
    is_dir   = offs[0];
    port_idx = offs[IDX_W:1];
    cur_val  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit && (port_idx == IDX_W'(p)))
        cur_val = is_dir ? dir_q[p] : rd_val[p];
    end
  end

  always_comb begin
    unique case (bop_kind_e'(bus_bop_kind))
      BOP_SET: mod_val = cur_val | (PORT_W'(1) << bus_bop_bit);
      BOP_CLR: mod_val = cur_val & ~(PORT_W'(1) << bus_bop_bit);
      BOP_TGL: mod_val = cur_val ^ (PORT_W'(1) << bus_bop_bit);
      default: mod_val = ~cur_val;
    endcase
    wr_val   = bus_wr ? bus_wdata : mod_val;
    write_go = hit && (bus_wr || bus_bop);
    for (int p = 0; p < NUM_PORTS; p++) begin
      data_we[p] = write_go && (port_idx == IDX_W'(p)) && !is_dir;
      dir_we[p]  = write_go && (port_idx == IDX_W'(p)) && is_dir;
    end
  end

  assign bus_rdata = cur_val;

  gpio_in_sync #(.LINES(LINES), .WAKE_W(PORT_W)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .pad_in(pad_in), .wake_mask(dir_q[0]),
    .pad_sync(pad_sync), .wake_req(wake_req)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_port #(.W(PORT_W)) u_port (
      .clk(clk), .rst_n(rst_s_n),
      .data_we(data_we[p]), .dir_we(dir_we[p]), .wval(wr_val),
      .pad_sync(pad_sync[p*PORT_W +: PORT_W]),
      .latch_q(latch_q[p]), .dir_q(dir_q[p]), .rd_val(rd_val[p])
    );
  end

  gpio_buzz u_buzz (
    .clk(clk), .rst_n(rst_s_n), .en(buzz_en), .ovf(tmr_ovf),
    .gate(buzz_en & latch_q[BUZ_PORT][0]), .buz_a(buz_a), .buz_b(buz_b)
  );

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      pad_oe[p*PORT_W +: PORT_W]  = ~dir_q[p];
      pad_out[p*PORT_W +: PORT_W] = latch_q[p];
    end
    if (buzz_en) begin
      pad_out[BUZ_PORT*PORT_W]     = buz_a;
      pad_out[BUZ_PORT*PORT_W + 1] = buz_b;
    end
    pad_float = ~pad_oe & ~PULL_HIGH;
  end

  // R12: a plain write wins over a simultaneous bit operation
  a_r12_write_priority: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && bus_bop && hit && !is_dir && port_idx == '0) |=> (latch_q[0] == $past(bus_wdata)));
  // R1: unmapped addresses read as zero
  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_addr < BASE_ADDR) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_gpio_port_bank.sv
`timescale 1ns/1ps
module tb_gpio_port_bank;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_wr, bus_bop;
  logic [2:0] bus_bop_bit;
  logic [1:0] bus_bop_kind;
  logic [55:0] pad_in, pad_oe, pad_out, pad_float;
  logic wake_req, buzz_en, tmr_ovf;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_bop(bus_bop),
    .bus_bop_bit(bus_bop_bit), .bus_bop_kind(bus_bop_kind), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_float(pad_float),
    .wake_req(wake_req), .buzz_en(buzz_en), .tmr_ovf(tmr_ovf)
  );

  // {address, write data, expected read-back}
  localparam logic [23:0] VECS [14] = '{
    24'h13_00_00, 24'h12_3C_3C, 24'h15_00_00, 24'h14_4D_4D,
    24'h17_00_00, 24'h16_5E_5E, 24'h19_00_00, 24'h18_6F_6F,
    24'h1B_00_00, 24'h1A_80_80, 24'h1D_00_00, 24'h1C_91_91,
    24'h1F_00_00, 24'h1E_A2_A2
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bop(input logic [7:0] a, input logic [2:0] b, input logic [1:0] k);
    @(negedge clk);
    bus_addr = a; bus_bop_bit = b; bus_bop_kind = k; bus_bop = 1'b1;
    @(negedge clk);
    bus_bop = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic pulse_ovf();
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; bus_wr = 1'b0; bus_bop = 1'b0;
    bus_bop_bit = 3'd0; bus_bop_kind = 2'b00; pad_in = '0; buzz_en = 1'b0; tmr_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 / R11 reset state
    chk("R5 oe", pad_oe, 56'h0);
    chk("R5 latch out", pad_out, {56{1'b1}});
    rd(8'h13, v); chk("R5 dir", v, 8'hFF);
    rd(8'h12, v); chk("R5 data reads pad", v, 8'h00);
    chk("R5 wake", wake_req, 1'b0);
    chk("R11 float", pad_float, 56'hFF_FFFF_FFFF_FF00);

    // R1 / R2 table walk
    for (int i = 0; i < 14; i++) begin
      wr(VECS[i][23:16], VECS[i][15:8]);
      rd(VECS[i][23:16], v);
      chk("R1 readback", v, VECS[i][7:0]);
    end
    chk("R2 out", pad_out, 56'hA2_9180_6F5E_4D3C);
    chk("R2 oe", pad_oe, {56{1'b1}});
    chk("R11 outputs not floating", pad_float, 56'h0);
    wr(8'h20, 8'h00);
    chk("R1 unmapped write", pad_out, 56'hA2_9180_6F5E_4D3C);
    rd(8'h20, v); chk("R1 unmapped hi", v, 8'h00);
    rd(8'h11, v); chk("R1 unmapped lo", v, 8'h00);

    // R3 mixed read and R4 latch hold on port D
    pad_in[31:24] = 8'h93;
    wr(8'h19, 8'hF0);
    rd(8'h18, v); chk("R3 mixed", v, 8'h9F);
    chk("R2 mixed oe", pad_oe[31:24], 8'h0F);
    wr(8'h19, 8'hFF);
    rd(8'h18, v); chk("R3 all pad", v, 8'h93);
    wr(8'h19, 8'h00);
    rd(8'h18, v); chk("R4 latch kept", v, 8'h6F);

    // R7 wake on port A
    wr(8'h13, 8'hFF);
    @(negedge clk); pad_in[2] = 1'b1;
    @(negedge clk); chk("R7 not yet", wake_req, 1'b0);
    @(negedge clk); chk("R7 wake", wake_req, 1'b1);
    @(negedge clk); chk("R7 one cycle", wake_req, 1'b0);
    wr(8'h13, 8'hFE);
    @(negedge clk); pad_in[0] = 1'b1; pad_in[16] = 1'b1;
    @(negedge clk); @(negedge clk); chk("R7 output line no wake", wake_req, 1'b0);
    @(negedge clk); chk("R7 output line no wake late", wake_req, 1'b0);

    // R6 read-modify-write on port C
    pad_in[23:16] = 8'hA3;
    wr(8'h17, 8'hF0);
    rd(8'h16, v); chk("R3 port C mixed", v, 8'hAE);
    bop(8'h16, 3'd0, 2'b00);
    wr(8'h17, 8'h00);
    rd(8'h16, v); chk("R6 set takes pad", v, 8'hAF);
    bop(8'h16, 3'd7, 2'b01); rd(8'h16, v); chk("R6 clear", v, 8'h2F);
    bop(8'h16, 3'd0, 2'b10); rd(8'h16, v); chk("R6 toggle", v, 8'h2E);
    bop(8'h16, 3'd0, 2'b11); rd(8'h16, v); chk("R6 invert", v, 8'hD1);
    @(negedge clk);
    bus_addr = 8'h16; bus_wdata = 8'h11; bus_wr = 1'b1;
    bus_bop = 1'b1; bus_bop_bit = 3'd7; bus_bop_kind = 2'b00;
    @(negedge clk); bus_wr = 1'b0; bus_bop = 1'b0;
    rd(8'h16, v); chk("R12 write wins", v, 8'h11);

    // R8 / R9 buzzer on port B lines 8 and 9
    @(negedge clk); buzz_en = 1'b1; #1;
    chk("R8 start", pad_out[9:8], 2'b10);
    pulse_ovf(); chk("R8 toggle1", pad_out[9:8], 2'b01);
    pulse_ovf(); chk("R8 toggle2", pad_out[9:8], 2'b10);
    pulse_ovf(); chk("R8 toggle3", pad_out[9:8], 2'b01);
    wr(8'h14, 8'h4E);
    chk("R9 gated low", pad_out[9:8], 2'b00);
    pulse_ovf(); chk("R9 still low", pad_out[9:8], 2'b00);
    wr(8'h14, 8'h4D);
    chk("R8 gate back on", pad_out[9:8], 2'b10);
    @(negedge clk); buzz_en = 1'b0;
    @(negedge clk); chk("R8 disabled shows latch", pad_out[9:8], 2'b01);
    buzz_en = 1'b1; #1;
    chk("R8 cleared", pad_out[9:8], 2'b10);

    // R10 input mode unaffected by buzzer
    pad_in[9:8] = 2'b10;
    wr(8'h15, 8'h03);
    chk("R10 oe", pad_oe[9:8], 2'b00);
    rd(8'h14, v); chk("R10 read pad", v, 8'h4E);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule